// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer seen by software through four 32-bit words on a simple register bus. Its inputs are an address, a write strobe, write data and a combinational read-data return. Two strobe inputs stand for the two candidate reference clocks. One of them is picked and divided down by a programmable prescaler into a slow tick, usually 1 ms. A 16-bit tick counter climbs once per tick toward a software-set limit. Firmware must write the kick word often enough to keep the counter below that limit.

When the counter reaches the limit, it stops. The block can then raise a one-cycle system reset request, a sticky interrupt, or both. It can also drive a reset pulse of programmable width and polarity on an external pin. Software can start or stop the timer without disturbing its other settings. It can also force a reset at once by writing a self-clearing bit.

Top module: `tick_watchdog`

## Requirements
- R1: After a synchronous reset, all three readable words read 0, and `rst_req_o`, `irq_o` and `ext_rst_o` are low.
- R2: The word at byte offset 0x0 holds these fields: bit 19 picks the clock source, bit 21 enables the reset request, bits 17:0 hold the divide value, bit 25 enables the divider, bit 18 is the run bit, bit 24 enables the clock and bit 23 enables the interrupt. The other bits of this word read 0. At offset 0x4, bit 16 sets the pin polarity, bits 15:0 set the pulse width and bit 17 enables the pin pulse; other bits read 0. At offset 0x8, bits 15:0 are the timeout and bits 31:16 are the read-only tick count, and writes do not change the count. A write whose address has bits 1:0 nonzero is ignored.
- R3: The prescaler emits one tick every D strobes of the selected source, where D is the divide value; a divide value of 0 acts as 1. Bit 19 = 0 selects `xtal_strobe_i` and bit 19 = 1 selects `alt_strobe_i`.
- R4: The tick count advances only while bits 18, 24 and 25 of offset 0x0 are all 1. Otherwise it holds its value. Clearing bit 18 and setting it again leaves the other fields as written.
- R5: A write of any data to offset 0xC sets the tick count to 0, overriding a tick on that same edge, and clears the interrupt.
- R6: When the count reaches the timeout, it freezes there until a kick. A timeout of 0 never produces an expiry.
- R7: On expiry with bit 21 set, `rst_req_o` is high for exactly the one cycle that follows the edge on which the count reaches the timeout. With bit 21 clear, it stays low.
- R8: On expiry with bit 23 set, `irq_o` goes high in the same cycle as the reset request and stays high until a kick.
- R9: Writing 1 to bit 26 at offset 0x0 raises `rst_req_o` for one cycle whatever bit 21 holds. Bit 26 reads back 1 in that cycle only, and the tick count is unaffected.
- R10: With bit 17 at offset 0x4 set, an expiry or forced reset drives `ext_rst_o` to its active level for exactly W cycles, where W is bits 15:0. The active level is low when bit 16 is 1 and high when bit 16 is 0. A width of 0 or a cleared bit 17 gives no pulse, and the idle level is the inverse of the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_strobe_i | input | 1 | Primary reference-clock strobe |
| alt_strobe_i | input | 1 | Alternate reference-clock strobe |
| bus_addr_i | input | 4 | Byte address of the register word |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Sticky expiry interrupt |
| ext_rst_o | output | 1 | External reset pulse pin |

## Verification
A register write takes effect on the rising edge where the write strobe is high, and a read right after that edge returns the new value. A tick produced at an edge is visible in the count word right after that same edge. So after the run bit is set, the count read k cycles later is k divided by D, capped at the timeout. The reset request, interrupt and pin pulse come from registers loaded on the expiry edge, so all three appear in the first sample after it: cycle k = T·D for timeout T. The bench drives inputs and samples outputs at falling edges and compares each sample against its own closed-form cycle count. It repeats this over random divide values, timeouts, widths, polarities and clock sources from a fixed seed.

// File: rtl/tick_watchdog_pkg.sv
package tick_watchdog_pkg;

    localparam int DIV_W = 18;
    localparam int CNT_W = 16;
    localparam int PW_W  = 16;

    // bit positions seen by software
    localparam int B_RUN    = 18;
    localparam int B_ALT    = 19;
    localparam int B_RSTEN  = 21;
    localparam int B_IRQEN  = 23;
    localparam int B_CLKEN  = 24;
    localparam int B_DIVEN  = 25;
    localparam int B_FORCE  = 26;
    localparam int B_POL    = 16;
    localparam int B_PULSE  = 17;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_PULSE = 2'd1,
        SEL_TIME  = 2'd2,
        SEL_KICK  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             force_rst;
        logic             div_en;
        logic             clk_en;
        logic             irq_en;
        logic             rst_en;
        logic             alt_sel;
        logic             run;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    typedef struct packed {
        logic            pulse_en;
        logic            active_low;
        logic [PW_W-1:0] width;
    } pulse_cfg_t;

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.div       = w[DIV_W-1:0];
        c.run       = w[B_RUN];
        c.alt_sel   = w[B_ALT];
        c.rst_en    = w[B_RSTEN];
        c.irq_en    = w[B_IRQEN];
        c.clk_en    = w[B_CLKEN];
        c.div_en    = w[B_DIVEN];
        c.force_rst = w[B_FORCE];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_t c);
        logic [31:0] w;
        w           = '0;
        w[DIV_W-1:0] = c.div;
        w[B_RUN]    = c.run;
        w[B_ALT]    = c.alt_sel;
        w[B_RSTEN]  = c.rst_en;
        w[B_IRQEN]  = c.irq_en;
        w[B_CLKEN]  = c.clk_en;
        w[B_DIVEN]  = c.div_en;
        w[B_FORCE]  = c.force_rst;
        return w;
    endfunction

    function automatic pulse_cfg_t pulse_unpack(input logic [31:0] w);
        pulse_cfg_t p;
        p.width      = w[PW_W-1:0];
        p.active_low = w[B_POL];
        p.pulse_en   = w[B_PULSE];
        return p;
    endfunction

    function automatic logic [31:0] pulse_pack(input pulse_cfg_t p);
        logic [31:0] w;
        w            = '0;
        w[PW_W-1:0]  = p.width;
        w[B_POL]     = p.active_low;
        w[B_PULSE]   = p.pulse_en;
        return w;
    endfunction

endpackage

// File: rtl/wd_prescaler.sv
module wd_prescaler #(
    parameter int W = tick_watchdog_pkg::DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active_i,
    input  logic         strobe_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] pre_q;
    logic [W-1:0] last;

    // a divide value of zero behaves as one
    assign last   = (div_i == '0) ? '0 : div_i - W'(1);
    assign tick_o = active_i && strobe_i && (pre_q >= last);

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            pre_q <= '0;
        end else if (strobe_i) begin
            pre_q <= tick_o ? '0 : pre_q + W'(1);
        end
    end

    // R3: without a strobe the phase of the divider is kept
    assert_pre_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (active_i && !strobe_i) |=> (pre_q == $past(pre_q)));

endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
    parameter int W = tick_watchdog_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         kick_i,
    input  logic [W-1:0] timeout_i,
    output logic [W-1:0] count_o,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;
    logic         adv;

    assign adv      = tick_i && !kick_i && (cnt_q != timeout_i);
    assign expire_o = adv && ((cnt_q + W'(1)) == timeout_i);
    assign count_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || kick_i) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assert_kick_clear_R5: assert property (@(posedge clk) disable iff (rst)
        kick_i |=> (cnt_q == '0));

    assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == timeout_i && !kick_i) |=> (cnt_q == $past(cnt_q)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !kick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wd_pulse.sv
module wd_pulse #(
    parameter int W = tick_watchdog_pkg::PW_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] width_i,
    input  logic         active_low_i,
    output logic         pin_o
);
    logic [W-1:0] left_q;
    logic         busy;

    assign busy  = (left_q != '0);
    assign pin_o = active_low_i ^ busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start_i) begin
            left_q <= width_i;
        end else if (busy) begin
            left_q <= left_q - W'(1);
        end
    end

    assert_pulse_load_R10: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (left_q == $past(width_i)));

    assert_pulse_dec_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !start_i) |=> (left_q == $past(left_q) - W'(1)));

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import tick_watchdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        xtal_strobe_i,
    input  logic        alt_strobe_i,
    input  logic [3:0]  bus_addr_i,
    input  logic        bus_we_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        rst_req_o,
    output logic        irq_o,
    output logic        ext_rst_o
);
    ctrl_t            ctrl_q;
    pulse_cfg_t       pcfg_q;
    logic [CNT_W-1:0] tout_q;
    logic [CNT_W-1:0] count;
    logic             rst_req_q;
    logic             irq_q;

    reg_sel_e sel;
    logic     aligned;
    logic     wr_ctrl, wr_pulse, wr_time, wr_kick, force_wr;
    logic     active, strobe, tick, expire, pulse_start;

    assign sel      = reg_sel_e'(bus_addr_i[3:2]);
    assign aligned  = (bus_addr_i[1:0] == 2'b00);
    assign wr_ctrl  = bus_we_i && aligned && (sel == SEL_CTRL);
    assign wr_pulse = bus_we_i && aligned && (sel == SEL_PULSE);
    assign wr_time  = bus_we_i && aligned && (sel == SEL_TIME);
    assign wr_kick  = bus_we_i && aligned && (sel == SEL_KICK);
    assign force_wr = wr_ctrl && bus_wdata_i[B_FORCE];

    assign active = ctrl_q.run && ctrl_q.clk_en && ctrl_q.div_en;
    assign strobe = ctrl_q.alt_sel ? alt_strobe_i : xtal_strobe_i;

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata_i[31:27], bus_wdata_i[22], bus_wdata_i[20]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pcfg_q <= '0;
            tout_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_unpack(bus_wdata_i);
            end else begin
                ctrl_q.force_rst <= 1'b0;
            end
            if (wr_pulse) pcfg_q <= pulse_unpack(bus_wdata_i);
            if (wr_time)  tout_q <= bus_wdata_i[CNT_W-1:0];
        end
    end

    wd_prescaler #(.W(DIV_W)) i_pre (
        .clk      (clk),
        .rst      (rst),
        .active_i (active),
        .strobe_i (strobe),
        .div_i    (ctrl_q.div),
        .tick_o   (tick)
    );

    wd_counter #(.W(CNT_W)) i_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .kick_i    (wr_kick),
        .timeout_i (tout_q),
        .count_o   (count),
        .expire_o  (expire)
    );

    assign pulse_start = pcfg_q.pulse_en && (expire || force_wr);

    wd_pulse #(.W(PW_W)) i_pin (
        .clk          (clk),
        .rst          (rst),
        .start_i      (pulse_start),
        .width_i      (pcfg_q.width),
        .active_low_i (pcfg_q.active_low),
        .pin_o        (ext_rst_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            rst_req_q <= (expire && ctrl_q.rst_en) || force_wr;
            if (wr_kick)                    irq_q <= 1'b0;
            else if (expire && ctrl_q.irq_en) irq_q <= 1'b1;
        end
    end

    assign rst_req_o = rst_req_q;
    assign irq_o     = irq_q;

    always_comb begin
        bus_rdata_o = '0;
        if (aligned) begin
            case (sel)
                SEL_CTRL:  bus_rdata_o = ctrl_pack(ctrl_q);
                SEL_PULSE: bus_rdata_o = pulse_pack(pcfg_q);
                SEL_TIME:  bus_rdata_o = {count, tout_q};
                default:   bus_rdata_o = '0;
            endcase
        end
    end

    assert_req_single_R7: assert property (@(posedge clk) disable iff (rst)
        (rst_req_q && !force_wr) |=> !rst_req_q);

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !wr_kick) |=> irq_q);

    assert_force_selfclear_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.force_rst && !force_wr) |=> !ctrl_q.force_rst);

    assert_count_ro_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_time && !tick && !wr_kick) |=> $stable(count));

endmodule

// File: tb/test_tick_watchdog.sv
module test_tick_watchdog;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xtal_strobe = 1'b0;
    logic        alt_strobe  = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req, irq, pin;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          done    = 1'b0;

    localparam logic [3:0] A_CTRL = 4'h0, A_PULSE = 4'h4, A_TIME = 4'h8, A_KICK = 4'hC;

    always #10 clk = ~clk;   // 50 MHz

    tick_watchdog i_tick_watchdog (
        .clk(clk), .rst(rst),
        .xtal_strobe_i(xtal_strobe), .alt_strobe_i(alt_strobe),
        .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .rst_req_o(rst_req), .irq_o(irq), .ext_rst_o(pin)
    );

    function automatic logic [31:0] ctrl_word(int div, bit run, bit alt, bit rsten,
                                              bit irqen, bit clken, bit diven, bit frc);
        logic [31:0] w;
        w = 32'(div) & 32'h3FFFF;
        w[18] = run; w[19] = alt; w[21] = rsten; w[23] = irqen;
        w[24] = clken; w[25] = diven; w[26] = frc;
        return w;
    endfunction

    function automatic logic [31:0] pulse_word(bit en, bit pol, int width);
        return (32'(en) << 17) | (32'(pol) << 16) | (32'(width) & 32'hFFFF);
    endfunction

    function automatic int exp_count(int k, int d, int t);
        int c;
        c = k / d;
        return (c > t) ? t : c;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int          seen;
        void'($urandom(32'd20240611));

        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(A_PULSE, v); chk("R1 pulse", v, 0);
        rd(A_TIME, v);  chk("R1 time", v, 0);
        chk("R1 outputs", {29'd0, rst_req, irq, pin}, 0);

        // R2 register map, reserved bits, read-only count, misaligned writes
        wr(A_CTRL, 32'hFBFF_FFFF);
        rd(A_CTRL, v);  chk("R2 ctrl fields", v, 32'h03AF_FFFF);
        wr(A_CTRL, 0);
        wr(A_PULSE, 32'hFFFF_FFFF);
        rd(A_PULSE, v); chk("R2 pulse fields", v, 32'h0003_FFFF);
        wr(A_PULSE, 0);
        wr(A_TIME, 32'hABCD_1234);
        rd(A_TIME, v);  chk("R2 count read-only", v, 32'h0000_1234);
        wr(4'h1, 32'h0000_FFFF);
        rd(A_CTRL, v);  chk("R2 misaligned ignored", v, 0);

        // R3 R6 R7 R8 R10 random expiry runs
        xtal_strobe = 1'b1;
        alt_strobe  = 1'b1;
        for (int it = 0; it < 8; it++) begin
            int  d, t, w, td;
            bit  pol, r, i, alt;
            d   = 1 + int'($urandom % 4);
            t   = 1 + int'($urandom % 6);
            w   = 1 + int'($urandom % 6);
            pol = bit'($urandom % 2);
            alt = bit'($urandom % 2);
            r   = (it % 2) == 0;
            i   = (it % 3) != 0;
            td  = t * d;
            wr(A_CTRL, 0);
            wr(A_KICK, 32'hDEAD_BEEF);
            wr(A_TIME, 32'(t));
            wr(A_PULSE, pulse_word(1'b1, pol, w));
            chk("R10 idle level", {31'd0, pin}, {31'd0, pol});
            chk("R5 irq cleared", {31'd0, irq}, 0);
            wr(A_CTRL, ctrl_word(d, 1, alt, r, i, 1, 1, 0));
            rd(A_TIME, v); chk("R3 count start", v, 32'(t));
            for (int k = 1; k <= td + w + 2; k++) begin
                step(1);
                rd(A_TIME, v);
                chk("R3 R6 count", v, (32'(exp_count(k, d, t)) << 16) | 32'(t));
                chk("R7 rst_req", {31'd0, rst_req}, {31'd0, r && (k == td)});
                chk("R8 irq", {31'd0, irq}, {31'd0, i && (k >= td)});
                chk("R10 pin", {31'd0, pin},
                    {31'd0, ((k >= td) && (k < td + w)) ? ~pol : pol});
            end
            wr(A_KICK, 0);
            rd(A_TIME, v); chk("R5 kick clears count", v >> 16, 0);
            chk("R5 kick clears irq", {31'd0, irq}, 0);
        end
        wr(A_CTRL, 0);
        wr(A_PULSE, 0);

        // R6 timeout zero never expires
        wr(A_KICK, 0);
        wr(A_TIME, 0);
        wr(A_CTRL, ctrl_word(1, 1, 0, 1, 1, 1, 1, 0));
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            step(1);
            if (rst_req || irq) seen++;
        end
        chk("R6 zero timeout no expiry", 32'(seen), 0);
        rd(A_TIME, v); chk("R6 zero timeout count", v, 0);

        // R4 enable gating
        wr(A_CTRL, 0);
        wr(A_KICK, 0);
        wr(A_TIME, 100);
        wr(A_CTRL, ctrl_word(1, 1, 0, 0, 0, 0, 1, 0));
        step(10);
        rd(A_TIME, v); chk("R4 clock gate holds", v >> 16, 0);
        wr(A_CTRL, ctrl_word(1, 1, 0, 0, 0, 1, 0, 0));
        step(10);
        rd(A_TIME, v); chk("R4 divider gate holds", v >> 16, 0);
        wr(A_CTRL, ctrl_word(1, 1, 0, 0, 0, 1, 1, 0));
        step(5);
        rd(A_TIME, v); chk("R4 runs", v >> 16, 5);
        wr(A_CTRL, ctrl_word(1, 0, 0, 0, 0, 1, 1, 0));
        step(10);
        rd(A_TIME, v); chk("R4 stopped holds", v >> 16, 6);
        rd(A_CTRL, v); chk("R4 fields kept", v, ctrl_word(1, 0, 0, 0, 0, 1, 1, 0));
        wr(A_CTRL, ctrl_word(1, 1, 0, 0, 0, 1, 1, 0));
        step(3);
        rd(A_TIME, v); chk("R4 restart", v >> 16, 9);

        // R5 kick mid-run, R2 timeout write leaves count
        wr(A_KICK, 32'h1234_5678);
        rd(A_TIME, v); chk("R5 kick mid-run", v >> 16, 0);
        step(4);
        rd(A_TIME, v); chk("R5 count after kick", v >> 16, 4);
        wr(A_CTRL, ctrl_word(1, 0, 0, 0, 0, 1, 1, 0));
        wr(A_TIME, 32'hFFFF_0064);
        rd(A_TIME, v); chk("R2 timeout write keeps count", v, 32'h0005_0064);

        // R3 source select and divide value zero
        wr(A_KICK, 0);
        xtal_strobe = 1'b1;
        alt_strobe  = 1'b0;
        wr(A_CTRL, ctrl_word(0, 1, 1, 0, 0, 1, 1, 0));
        step(5);
        rd(A_TIME, v); chk("R3 unselected source ignored", v >> 16, 0);
        alt_strobe = 1'b1;
        step(3);
        rd(A_TIME, v); chk("R3 alternate source, divide 0", v >> 16, 3);
        alt_strobe = 1'b0;
        step(2);
        rd(A_TIME, v); chk("R3 no strobe no tick", v >> 16, 3);
        wr(A_CTRL, 0);

        // R9 forced reset with pulse
        wr(A_KICK, 0);
        wr(A_PULSE, pulse_word(1'b1, 1'b0, 3));
        wr(A_CTRL, ctrl_word(0, 0, 0, 0, 0, 0, 0, 1));
        chk("R9 force rst_req", {31'd0, rst_req}, 1);
        rd(A_CTRL, v); chk("R9 force bit reads 1", v, 32'h0400_0000);
        chk("R10 force pulse c0", {31'd0, pin}, 1);
        step(1);
        chk("R9 force rst_req one cycle", {31'd0, rst_req}, 0);
        rd(A_CTRL, v); chk("R9 force bit clears", v, 0);
        chk("R10 force pulse c1", {31'd0, pin}, 1);
        step(1);
        chk("R10 force pulse c2", {31'd0, pin}, 1);
        step(1);
        chk("R10 force pulse end", {31'd0, pin}, 0);
        rd(A_TIME, v); chk("R9 count unaffected", v >> 16, 0);

        // R10 width zero and disabled pulse
        wr(A_PULSE, pulse_word(1'b1, 1'b1, 0));
        wr(A_CTRL, ctrl_word(0, 0, 0, 0, 0, 0, 0, 1));
        seen = 0;
        for (int k = 0; k < 4; k++) begin
            if (pin !== 1'b1) seen++;
            step(1);
        end
        chk("R10 width zero no pulse", 32'(seen), 0);
        wr(A_PULSE, pulse_word(1'b0, 1'b0, 5));
        wr(A_CTRL, ctrl_word(0, 0, 0, 0, 0, 0, 0, 1));
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            if (pin !== 1'b0) seen++;
            step(1);
        end
        chk("R10 disabled pulse", 32'(seen), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule